// File: doc/BRIEF.md
# SPI Flash Identification Responder

This block is the device side of a serial NOR flash interface, cut down to the identification commands only. A host selects it by pulling the active-low chip select, then shifts in an opcode byte, most significant bit first, on the serial data input. When the opcode is one of the identification commands, the block answers on the serial data output with a fixed sequence of manufacturer and device code bytes. It drives the output enable only while those bytes are being shifted out. Any other opcode is ignored until the next select. Raising chip select at any point returns the block to standby and clears every piece of transaction state.

The serial pins are asynchronous to the block's own clock. They pass through a synchronizer, and the block detects the serial clock edges itself, so the serial clock has to run well below the system clock. The protocol is SPI mode 0: input bits are taken on the rising serial clock edge and output bits change after the falling edge. The signature opcode and the three two-byte opcodes wait for three address or dummy bytes before answering. For the two-byte opcodes, bit 0 of the last address byte swaps the order of the two codes. The three-byte identification opcode answers at once, with no address. While chip select stays low, every answer repeats from its first byte.

The controlling state machine has five named states. IDLE is standby. OPCODE receives the command byte. ADDR counts the address or dummy bytes. RESPOND shifts out the ID bytes. IGNORE sits out an unknown command. The transitions are: select moves IDLE to OPCODE. A completed opcode byte moves OPCODE to ADDR (0xAB, 0x90, 0xEF, 0xDF), to RESPOND (0x9F) or to IGNORE (anything else). The last address byte moves ADDR to RESPOND. Deselect moves any state back to IDLE. RESPOND and IGNORE hold until deselect.

Top module: `spi_id_responder`

## Requirements
- R1: While chip select (synchronized) is high, the output enable is 0, the data output is 0 and the state is IDLE. A transaction cut short by deselect leaves nothing behind, and the next select decodes a fresh opcode.
- R2: Mode 0 timing. Input bits are taken on rising serial clock edges, most significant bit first. The data output changes only after a falling serial clock edge, so it is stable while the serial clock is high.
- R3: Opcode 0xAB, followed by three dummy bytes of any value, returns the byte 0x17. Address bit 0 has no effect for this opcode.
- R4: Opcode 0x90, followed by three address bytes whose last byte has bit 0 = 0, returns 0xC2 and then 0x17.
- R5: Opcode 0x90 with bit 0 of the last address byte = 1 returns 0x17 and then 0xC2.
- R6: Opcodes 0xEF and 0xDF behave exactly like 0x90, including the order swap controlled by address bit 0.
- R7: Opcode 0x9F, with no address bytes, returns 0xC2, 0x20 and 0x18 in that order.
- R8: While chip select stays low after the last ID byte, the sequence repeats from its first byte with no gap.
- R9: An opcode outside {0xAB, 0x90, 0xEF, 0xDF, 0x9F} gives no response for the rest of that select: the output enable stays 0 whatever follows on the input.
- R10: The output enable is 0 during all opcode and address bits. It rises at the first falling serial clock edge after the last command bit and stays 1 until deselect.
- R11: A select that ends partway through an opcode or address byte does not affect the next transaction, which answers as if it were the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_sclk | input | 1 | Serial clock from the host, idle low (mode 0) |
| spi_mosi | input | 1 | Serial data from the host, MSB first |
| spi_miso | output | 1 | Serial data to the host, valid while spi_miso_oe is 1 |
| spi_miso_oe | output | 1 | Output enable for the serial data output pad |

## Verification
The bench drives the first two-byte opcode with address bit 0 at both values, and drives the signature opcode with bit 0 set. A design that latched the wrong address bit, or applied the swap to the signature opcode, would return the codes in the wrong order or return 0xC2 in place of 0x17. Each answer is read past its own length, so an index that fails to wrap would shift out a stray byte or stall at the last one. An unknown opcode is followed by several bytes of traffic, so a decoder that fell back to answering would raise the output enable. A select cut off after four opcode bits checks that the bit counter is cleared: a block that kept the stale count would misframe the next opcode and stay silent or answer wrongly.

// File: rtl/spi_id_responder_pkg.sv
package spi_id_responder_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RESPOND,
        ST_IGNORE
    } idr_state_t;

    typedef enum logic [1:0] {
        ID_NONE,
        ID_SIG,
        ID_PAIR,
        ID_JEDEC
    } id_kind_t;

    localparam logic [7:0] OP_SIG    = 8'hAB;
    localparam logic [7:0] OP_PAIR_A = 8'h90;
    localparam logic [7:0] OP_PAIR_B = 8'hEF;
    localparam logic [7:0] OP_PAIR_C = 8'hDF;
    localparam logic [7:0] OP_JEDEC  = 8'h9F;

    function automatic id_kind_t decode_opcode(input logic [7:0] op);
        id_kind_t k;
        case (op)
            OP_SIG:                          k = ID_SIG;
            OP_PAIR_A, OP_PAIR_B, OP_PAIR_C: k = ID_PAIR;
            OP_JEDEC:                        k = ID_JEDEC;
            default:                         k = ID_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [1:0] id_length(input id_kind_t k);
        logic [1:0] n;
        case (k)
            ID_PAIR:  n = 2'd2;
            ID_JEDEC: n = 2'd3;
            default:  n = 2'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sclk_pin,
    input  logic mosi_pin,
    output logic cs_s,
    output logic mosi_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    localparam int W = 3;
    localparam logic [W-1:0] IDLE_PINS = 3'b001; // {mosi, sclk, cs_n}

    logic [W-1:0] chain_q [STAGES];
    logic         sclk_prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= IDLE_PINS;
                    else        chain_q[g] <= {mosi_pin, sclk_pin, cs_n_pin};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= IDLE_PINS;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= chain_q[STAGES-1][1];
    end

    assign cs_s      = chain_q[STAGES-1][0];
    assign mosi_s    = chain_q[STAGES-1][2];
    assign sclk_rise =  chain_q[STAGES-1][1] & ~sclk_prev_q;
    assign sclk_fall = ~chain_q[STAGES-1][1] &  sclk_prev_q;

endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      shift_en,
    input  logic                      bit_in,
    output logic [BYTE_W-1:0]         byte_val,
    output logic                      byte_done,
    output logic [$clog2(BYTE_W)-1:0] bit_cnt
);
    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [BYTE_W-2:0] sr_q;
    logic [CW-1:0]     cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            sr_q  <= byte_val[BYTE_W-2:0];
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign byte_val  = {sr_q, bit_in};
    assign byte_done = shift_en && (cnt_q == LAST);
    assign bit_cnt   = cnt_q;

endmodule

// File: rtl/spi_id_table.sv
module spi_id_table
    import spi_id_responder_pkg::*;
#(
    parameter logic [7:0] MFR_ID     = 8'hC2,
    parameter logic [7:0] DEV_SIG    = 8'h17,
    parameter logic [7:0] JEDEC_TYPE = 8'h20,
    parameter logic [7:0] JEDEC_CAP  = 8'h18
) (
    input  id_kind_t   kind,
    input  logic [1:0] idx,
    input  logic       swap,
    output logic [7:0] id_byte
);
    always_comb begin
        id_byte = 8'h00;
        case (kind)
            ID_SIG:   id_byte = DEV_SIG;
            ID_PAIR:  id_byte = (idx[0] ^ swap) ? DEV_SIG : MFR_ID;
            ID_JEDEC: begin
                case (idx)
                    2'd0:    id_byte = MFR_ID;
                    2'd1:    id_byte = JEDEC_TYPE;
                    default: id_byte = JEDEC_CAP;
                endcase
            end
            default:  id_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder #(
    parameter int         SYNC_STAGES = 2,
    parameter int         ADDR_BYTES  = 3,
    parameter logic [7:0] MFR_ID      = 8'hC2,
    parameter logic [7:0] DEV_SIG     = 8'h17,
    parameter logic [7:0] JEDEC_TYPE  = 8'h20,
    parameter logic [7:0] JEDEC_CAP   = 8'h18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sclk,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    import spi_id_responder_pkg::*;

    localparam int BYTE_W = 8;
    localparam int BCW    = $clog2(BYTE_W);
    localparam int ACW    = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [ACW-1:0] ADDR_LAST = ACW'(ADDR_BYTES - 1);

    // synchronized pins and serial clock edges
    logic cs_s, mosi_s, sclk_rise, sclk_fall;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_pin  (spi_cs_n),
        .sclk_pin  (spi_sclk),
        .mosi_pin  (spi_mosi),
        .cs_s      (cs_s),
        .mosi_s    (mosi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    // input byte framing
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_done;
    logic [BCW-1:0]    bit_cnt;

    spi_byte_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_s),
        .shift_en  (sclk_rise),
        .bit_in    (mosi_s),
        .byte_val  (rx_byte),
        .byte_done (rx_done),
        .bit_cnt   (bit_cnt)
    );

    // transaction context
    idr_state_t     state_q, state_d;
    id_kind_t       kind_q;
    id_kind_t       op_kind;
    logic [ACW-1:0] addr_cnt;
    logic           addr_last;
    logic           swap_q;
    logic [1:0]     byte_idx;
    logic [1:0]     id_len;
    logic [7:0]     id_byte;

    assign op_kind   = decode_opcode(rx_byte);
    assign addr_last = (addr_cnt == ADDR_LAST);
    assign id_len    = id_length(kind_q);

    spi_id_table #(
        .MFR_ID     (MFR_ID),
        .DEV_SIG    (DEV_SIG),
        .JEDEC_TYPE (JEDEC_TYPE),
        .JEDEC_CAP  (JEDEC_CAP)
    ) u_table (
        .kind    (kind_q),
        .idx     (byte_idx),
        .swap    (swap_q),
        .id_byte (id_byte)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_OPCODE;
                ST_OPCODE: begin
                    if (rx_done) begin
                        case (op_kind)
                            ID_NONE:  state_d = ST_IGNORE;
                            ID_JEDEC: state_d = ST_RESPOND;
                            default:  state_d = ST_ADDR;
                        endcase
                    end
                end
                ST_ADDR:    if (rx_done && addr_last) state_d = ST_RESPOND;
                ST_RESPOND: state_d = ST_RESPOND;
                ST_IGNORE:  state_d = ST_IGNORE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= ID_NONE;
            addr_cnt <= '0;
            swap_q   <= 1'b0;
            byte_idx <= '0;
        end else if (cs_s) begin
            kind_q   <= ID_NONE;
            addr_cnt <= '0;
            swap_q   <= 1'b0;
            byte_idx <= '0;
        end else if (rx_done) begin
            unique case (state_q)
                ST_OPCODE: kind_q <= op_kind;
                ST_ADDR: begin
                    if (addr_last) swap_q <= mosi_s;
                    else           addr_cnt <= addr_cnt + 1'b1;
                end
                ST_RESPOND: byte_idx <= (byte_idx == id_len - 2'd1) ? 2'd0
                                                                    : byte_idx + 2'd1;
                default: ;
            endcase
        end
    end

    // output register: updated on falling serial clock only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_miso    <= 1'b0;
            spi_miso_oe <= 1'b0;
        end else if (cs_s) begin
            spi_miso    <= 1'b0;
            spi_miso_oe <= 1'b0;
        end else if (sclk_fall && state_q == ST_RESPOND) begin
            spi_miso    <= id_byte[BCW'(BYTE_W - 1) - bit_cnt];
            spi_miso_oe <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_id_responder_chk.sv
module spi_id_responder_chk
    import spi_id_responder_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       sclk_fall,
    input idr_state_t state_q,
    input logic [1:0] byte_idx,
    input logic [1:0] id_len,
    input logic       spi_miso,
    input logic       spi_miso_oe
);
    assert_standby_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (state_q == ST_IDLE && !spi_miso_oe && !spi_miso));

    assert_miso_fall_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_s) |=> $stable(spi_miso));

    assert_index_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESPOND) |-> (byte_idx < id_len));

    assert_ignore_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !spi_miso_oe);

    assert_ignore_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && !cs_s) |=> (state_q == ST_IGNORE));

    assert_oe_respond_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> (state_q == ST_RESPOND));

endmodule

bind spi_id_responder spi_id_responder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .sclk_fall   (sclk_fall),
    .state_q     (state_q),
    .byte_idx    (byte_idx),
    .id_len      (id_len),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe)
);

// File: tb/spi_id_responder_test.sv
module spi_id_responder_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;   // system clocks per serial half period
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_sclk = 1'b0;
    logic spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;

    int checks = 0;
    int errors = 0;
    int r2_bad = 0;
    logic prev_miso = 1'b0;
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_id_responder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sclk    (spi_sclk),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe)
    );

    // per-clock monitor for R2: enabled data may not move while sclk is high
    always @(negedge clk) begin
        if (rst_n && spi_miso_oe && spi_sclk && spi_miso !== prev_miso) r2_bad++;
        prev_miso = spi_miso;
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // behavioural reference: ID byte k of the answer to opcode op
    function automatic logic [7:0] model_byte(input logic [7:0] op, input logic swap, input int k);
        logic [7:0] seq3 [3];
        seq3[0] = 8'hC2; seq3[1] = 8'h20; seq3[2] = 8'h18;
        case (op)
            8'hAB: return 8'h17;
            8'h90, 8'hEF, 8'hDF: return (((k % 2) == 1) ^ swap) ? 8'h17 : 8'hC2;
            8'h9F: return seq3[k % 3];
            default: return 8'h00;
        endcase
    endfunction

    task automatic spi_bit(input logic b_out, output logic b_in, output logic oe_seen);
        spi_mosi = b_out;
        repeat (HALF) @(negedge clk);
        b_in    = spi_miso;
        oe_seen = spi_miso_oe;
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic select;
        spi_cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic deselect(input string tag);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check({tag, " R1 oe after deselect"}, spi_miso_oe, 0);
    endtask

    task automatic send_byte(input logic [7:0] b, output int oe_hits);
        logic bi, oe;
        oe_hits = 0;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(b[i], bi, oe);
            if (oe) oe_hits++;
        end
    endtask

    task automatic recv_byte(output logic [7:0] b, output int oe_hits);
        logic bi, oe;
        oe_hits = 0;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(1'b0, bi, oe);
            b[i] = bi;
            if (oe) oe_hits++;
        end
    endtask

    // full identification transaction; quiet=1 expects no answer at all
    task automatic id_cmd(input logic [7:0] op, input int naddr, input logic [7:0] addr_lsb,
                          input int nresp, input bit quiet, input string tag);
        int cmd_oe, hits, got_oe;
        logic [7:0] got;
        logic swap;
        cmd_oe = 0;
        swap = (op == 8'h90 || op == 8'hEF || op == 8'hDF) ? addr_lsb[0] : 1'b0;
        exp_q.delete();
        for (int k = 0; k < nresp; k++) exp_q.push_back(model_byte(op, swap, k));
        select();
        send_byte(op, hits); cmd_oe += hits;
        for (int a = 0; a < naddr; a++) begin
            send_byte((a == naddr - 1) ? addr_lsb : 8'h00, hits);
            cmd_oe += hits;
        end
        check({tag, " R10 oe low during command"}, cmd_oe, 0);
        got_oe = 0;
        for (int k = 0; k < nresp; k++) begin
            logic [7:0] e;
            recv_byte(got, hits);
            got_oe += hits;
            e = exp_q.pop_front();
            if (!quiet) check($sformatf("%s byte %0d", tag, k), got, e);
        end
        if (quiet) check({tag, " R9 no answer"}, got_oe, 0);
        else       check({tag, " R10 oe high while answering"}, got_oe, nresp * 8);
        deselect(tag);
    endtask

    initial begin : main
        int hits;
        repeat (5) @(negedge clk);
        check("R1 reset oe", spi_miso_oe, 0);
        check("R1 reset miso", spi_miso, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        id_cmd(8'h9F, 0, 8'h00, 6, 1'b0, "R7/R8 jedec");
        id_cmd(8'hAB, 3, 8'h00, 3, 1'b0, "R3/R8 signature");
        id_cmd(8'hAB, 3, 8'h01, 2, 1'b0, "R3 signature addr1");
        id_cmd(8'h90, 3, 8'h00, 4, 1'b0, "R4/R8 pair");
        id_cmd(8'h90, 3, 8'h01, 3, 1'b0, "R5 pair swapped");
        id_cmd(8'hEF, 3, 8'h00, 2, 1'b0, "R6 EF");
        id_cmd(8'hEF, 3, 8'h5B, 2, 1'b0, "R6 EF swapped");
        id_cmd(8'hDF, 3, 8'hFF, 2, 1'b0, "R6 DF swapped");
        id_cmd(8'hDF, 3, 8'hFE, 2, 1'b0, "R6 DF");
        id_cmd(8'h03, 0, 8'h00, 4, 1'b1, "R9 unknown 03");
        id_cmd(8'h9E, 0, 8'h00, 3, 1'b1, "R9 unknown 9E");

        // R11: deselect after half an opcode, then a clean command
        select();
        for (int i = 7; i >= 4; i--) begin
            logic bi, oe;
            spi_bit(8'h9F >> i, bi, oe);
        end
        deselect("R11 abort");
        id_cmd(8'h9F, 0, 8'h00, 3, 1'b0, "R11 after abort");

        // R11: deselect partway through address bytes
        select();
        send_byte(8'h90, hits);
        send_byte(8'h00, hits);
        deselect("R11 abort addr");
        id_cmd(8'h90, 3, 8'h01, 2, 1'b0, "R11/R5 after addr abort");

        check("R2 miso moved while sclk high", r2_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule